// File: doc/BRIEF.md
# Receiver Error Logger with Sample Concealment

This block sits behind the front end of a biphase-coded digital audio receiver. Once per sample frame the front end presents one audio word and a set of error strobes: parity, biphase coding, PLL unlock, validity bit, channel-status CRC and Q-subcode CRC. The block adds a derived confidence error, which is unlock OR biphase. It gates each error through a mask and records the unmasked ones in a sticky status register that clears when it is read. It produces a one-cycle error pulse and a level interrupt. For each sample it decides whether to pass the word, repeat the last good word, or output zero.

A small register port gives access to the status, mask and hold-mode fields. Two straps are captured while reset is held. One selects a register-free hardware mode. The other decides whether, in that mode, a set validity bit counts as an error.

Top module: `rx_err_logger`

## Requirements
- R1: The confidence error (status bit 2) is logged when unlock or biphase is flagged on a frame and bit 2 is unmasked.
- R2: Status and mask share one layout: bit 0 parity, bit 1 biphase, bit 2 confidence, bit 3 validity, bit 4 unlock, bit 5 channel-status CRC, bit 6 Q-subcode CRC. Bit 7 reads as 0.
- R3: A status bit sets on an unmasked error in its frame and stays set until a read of address 0. That read returns the value before clearing, and an error arriving on the same cycle as the read stays set.
- R4: The mask resets to all zeros (all errors masked). A masked error is not logged, gives no pulse and does not alter the sample.
- R5: `errPulse` is high for exactly the one cycle after each frame that carries at least one unmasked error, CRC errors included.
- R6: `irq` is high whenever any status bit is set whose mask bit is also set, and is low out of reset.
- R7: The hold field (address 2, bits 1:0, reset 0) selects the action on a frame with an unmasked parity, biphase, confidence, validity or unlock error. Code 0 repeats the previous good sample, code 1 outputs zero, and codes 2 and 3 pass the sample unchanged.
- R8: Channel-status CRC and Q-subcode CRC errors never alter the output sample, even when unmasked.
- R9: The previous-good register resets to zero and loads only from frames that carry no unmasked error of the sample-affecting class. A repeat issued before any good frame outputs zero.
- R10: With `hwStrap` high during reset, the mask and hold registers are ignored. Parity, biphase, confidence and unlock always repeat the previous good sample. Validity acts the same way only if `validStrap` was high during reset. CRC errors are masked. Strap changes after reset have no effect.
- R11: `sampleOut` and `sampleOutValid` update on the clock edge that samples `frameStb`. `sampleOutValid` is high for one cycle per frame, and `sampleOut` holds its value between frames.
- R12: The register addresses are 0 for status (writes ignored), 1 for mask and 2 for hold. Address 3 reads as 0. `regRdata` is registered, so it is valid the cycle after `regRd`, and a write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; the straps are captured while it is low |
| hwStrap | input | 1 | Hardware-mode strap |
| validStrap | input | 1 | Hardware mode: validity counts as an error |
| frameStb | input | 1 | One-cycle strobe per sample frame |
| sampleIn | input | SAMPLE_W | Audio word of the frame |
| parErr | input | 1 | Parity error for the frame |
| bipErr | input | 1 | Biphase coding error for the frame |
| unlockErr | input | 1 | PLL not locked during the frame |
| validBit | input | 1 | Validity bit of the frame is set |
| csCrcErr | input | 1 | Channel-status CRC error |
| qCrcErr | input | 1 | Q-subcode CRC error |
| regAddr | input | 2 | Register address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | REG_W | Write data |
| regRdata | output | REG_W | Read data, one cycle after `regRd` |
| sampleOut | output | SAMPLE_W | Concealed audio word |
| sampleOutValid | output | 1 | Output word updated |
| errPulse | output | 1 | One-cycle pulse per errored frame |
| irq | output | 1 | Interrupt level |

## Verification
The hardest case to reach is an error frame that lands on the same edge as the clearing read of status. The read must return the old bits while the new bit survives the clear. Directed steps drive a read and an errored frame together and then read again. The random phase also overlaps reads with frames often. A second hard case is the first-frame hold with the previous-good register still at zero. Reaching it needs a fresh reset followed at once by an errored frame.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int NUM_ERR   = 7;
  localparam int ADDR_W    = 2;
  localparam int BIT_PAR   = 0;
  localparam int BIT_BIP   = 1;
  localparam int BIT_CONF  = 2;
  localparam int BIT_VALID = 3;
  localparam int BIT_UNL   = 4;
  localparam int BIT_CSCRC = 5;
  localparam int BIT_QCRC  = 6;

  localparam logic [NUM_ERR-1:0] ACTION_CLASS =
    NUM_ERR'((1 << BIT_PAR) | (1 << BIT_BIP) | (1 << BIT_CONF) | (1 << BIT_VALID) | (1 << BIT_UNL));
  localparam logic [NUM_ERR-1:0] HW_BASE_MASK =
    NUM_ERR'((1 << BIT_PAR) | (1 << BIT_BIP) | (1 << BIT_CONF) | (1 << BIT_UNL));

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HOLD   = 2'd2;

  typedef enum logic [1:0] {
    HOLD_REPEAT = 2'd0,
    HOLD_ZERO   = 2'd1,
    HOLD_PASS   = 2'd2,
    HOLD_PASS2  = 2'd3
  } holdMode_e;

  typedef struct packed {
    logic frameGo;
    logic useHeld;
    logic useZero;
    logic saveGood;
  } dpStb_t;
endpackage

// File: rtl/rx_err_ctrl.sv
module rx_err_ctrl
  import rx_err_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hwStrap,
  input  logic                 validStrap,
  input  logic                 frameStb,
  input  logic                 parErr,
  input  logic                 bipErr,
  input  logic                 unlockErr,
  input  logic                 validBit,
  input  logic                 csCrcErr,
  input  logic                 qCrcErr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  output logic                 errPulse,
  output logic                 irq,
  output dpStb_t               dpStb
);
  localparam int HOLD_W = 2;

  logic                 hwModeQ;
  logic                 validInclQ;
  logic [NUM_ERR-1:0]   statusQ;
  logic [NUM_ERR-1:0]   maskQ;
  holdMode_e            holdQ;
  logic [NUM_ERR-1:0]   errVec;
  logic [NUM_ERR-1:0]   effMask;
  logic [NUM_ERR-1:0]   hitVec;
  logic [NUM_ERR-1:0]   actVec;
  logic                 statusClr;
  holdMode_e            holdSel;

  // Straps follow their pins while reset is held and freeze afterwards.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hwModeQ    <= hwStrap;
      validInclQ <= validStrap;
    end
  end

  always_comb begin
    errVec            = '0;
    errVec[BIT_PAR]   = parErr;
    errVec[BIT_BIP]   = bipErr;
    errVec[BIT_CONF]  = unlockErr | bipErr;
    errVec[BIT_VALID] = validBit;
    errVec[BIT_UNL]   = unlockErr;
    errVec[BIT_CSCRC] = csCrcErr;
    errVec[BIT_QCRC]  = qCrcErr;
  end

  always_comb begin
    effMask = maskQ;
    if (hwModeQ) begin
      effMask = HW_BASE_MASK;
      effMask[BIT_VALID] = validInclQ;
    end
  end

  assign hitVec    = frameStb ? (errVec & effMask) : '0;
  assign actVec    = hitVec & ACTION_CLASS;
  assign holdSel   = hwModeQ ? HOLD_REPEAT : holdQ;
  assign statusClr = regRd && (regAddr == ADDR_STATUS);

  always_comb begin
    dpStb.frameGo  = frameStb;
    dpStb.useHeld  = (|actVec) && (holdSel == HOLD_REPEAT);
    dpStb.useZero  = (|actVec) && (holdSel == HOLD_ZERO);
    dpStb.saveGood = frameStb && !(|actVec);
  end

  // Sticky status bits: a new hit outranks the clear of the same edge.
  for (genvar i = 0; i < NUM_ERR; i++) begin : g_status
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          statusQ[i] <= 1'b0;
      else if (hitVec[i]) statusQ[i] <= 1'b1;
      else if (statusClr) statusQ[i] <= 1'b0;
    end

    assert_sticky_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[i] && !statusClr) |=> statusQ[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ    <= '0;
      holdQ    <= HOLD_REPEAT;
      regRdata <= '0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= |hitVec;
      if (regWr) begin
        unique case (regAddr)
          ADDR_MASK: maskQ <= regWdata[NUM_ERR-1:0];
          ADDR_HOLD: holdQ <= holdMode_e'(regWdata[HOLD_W-1:0]);
          default:   ;
        endcase
      end
      if (regRd) begin
        unique case (regAddr)
          ADDR_STATUS: regRdata <= REG_W'(statusQ);
          ADDR_MASK:   regRdata <= REG_W'(maskQ);
          ADDR_HOLD:   regRdata <= REG_W'(holdQ);
          default:     regRdata <= '0;
        endcase
      end
    end
  end

  assign irq = |(statusQ & effMask);

  assert_pulse_from_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(frameStb));

  assert_irq_rise_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(frameStb) || $past(regWr)));

  assert_one_action_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dpStb.useHeld, dpStb.useZero}));

  assert_crc_no_action_R8: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && !parErr && !bipErr && !unlockErr && !validBit)
      |-> (!dpStb.useHeld && !dpStb.useZero && dpStb.saveGood));
endmodule

// File: rtl/rx_err_datapath.sv
module rx_err_datapath
  import rx_err_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStb_t              dpStb,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleOutValid
);
  logic [SAMPLE_W-1:0] prevGood;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevGood       <= '0;
      sampleOut      <= '0;
      sampleOutValid <= 1'b0;
    end else begin
      sampleOutValid <= dpStb.frameGo;
      if (dpStb.frameGo) begin
        if (dpStb.useHeld)      sampleOut <= prevGood;
        else if (dpStb.useZero) sampleOut <= '0;
        else                    sampleOut <= sampleIn;
      end
      if (dpStb.saveGood) prevGood <= sampleIn;
    end
  end

  assert_saved_matches_out_R9: assert property (@(posedge clk) disable iff (!rstN)
    dpStb.saveGood |=> (sampleOut == prevGood));

  assert_strobes_need_frame_R11: assert property (@(posedge clk) disable iff (!rstN)
    (dpStb.useHeld || dpStb.useZero || dpStb.saveGood) |-> dpStb.frameGo);
endmodule

// File: rtl/rx_err_logger.sv
module rx_err_logger
  import rx_err_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int REG_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hwStrap,
  input  logic                validStrap,
  input  logic                frameStb,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                parErr,
  input  logic                bipErr,
  input  logic                unlockErr,
  input  logic                validBit,
  input  logic                csCrcErr,
  input  logic                qCrcErr,
  input  logic [1:0]          regAddr,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleOutValid,
  output logic                errPulse,
  output logic                irq
);
  dpStb_t dpStb;

  rx_err_ctrl #(.REG_W(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .hwStrap(hwStrap), .validStrap(validStrap),
    .frameStb(frameStb), .parErr(parErr), .bipErr(bipErr),
    .unlockErr(unlockErr), .validBit(validBit), .csCrcErr(csCrcErr),
    .qCrcErr(qCrcErr), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .errPulse(errPulse),
    .irq(irq), .dpStb(dpStb)
  );

  rx_err_datapath #(.SAMPLE_W(SAMPLE_W)) uData (
    .clk(clk), .rstN(rstN), .dpStb(dpStb), .sampleIn(sampleIn),
    .sampleOut(sampleOut), .sampleOutValid(sampleOutValid)
  );
endmodule

// File: tb/rx_err_logger_test.sv
module rx_err_logger_test;
  localparam int SW = 24;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hwStrap = 1'b0, validStrap = 1'b0;
  logic frameStb = 1'b0;
  logic [SW-1:0] sampleIn = '0;
  logic parErr = 0, bipErr = 0, unlockErr = 0, validBit = 0, csCrcErr = 0, qCrcErr = 0;
  logic [1:0] regAddr = '0;
  logic regWr = 0, regRd = 0;
  logic [RW-1:0] regWdata = '0;
  logic [RW-1:0] regRdata;
  logic [SW-1:0] sampleOut;
  logic sampleOutValid, errPulse, irq;

  int total = 0;
  int bad = 0;

  // Model state
  logic [6:0] mStatus, mMask;
  logic [1:0] mHold;
  logic [SW-1:0] mPrev, mOut;
  logic mHw, mVal;

  always #5 clk = ~clk;

  rx_err_logger #(.SAMPLE_W(SW), .REG_W(RW)) uut (
    .clk(clk), .rstN(rstN), .hwStrap(hwStrap), .validStrap(validStrap),
    .frameStb(frameStb), .sampleIn(sampleIn), .parErr(parErr), .bipErr(bipErr),
    .unlockErr(unlockErr), .validBit(validBit), .csCrcErr(csCrcErr), .qCrcErr(qCrcErr),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .sampleOut(sampleOut), .sampleOutValid(sampleOutValid),
    .errPulse(errPulse), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] errVecOf(input logic [5:0] fl);
    // fl: 0 par, 1 bip, 2 unlock, 3 valid, 4 cs crc, 5 q crc
    return {fl[5], fl[4], fl[2], fl[3], fl[2] | fl[1], fl[1], fl[0]};
  endfunction

  function automatic logic [6:0] effMaskOf();
    if (mHw) return {2'b00, 1'b1, mVal, 3'b111};
    return mMask;
  endfunction

  task automatic doReset(input logic hw, input logic vs);
    @(negedge clk);
    rstN = 1'b0; hwStrap = hw; validStrap = vs;
    frameStb = 0; regRd = 0; regWr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mStatus = '0; mMask = '0; mHold = '0; mPrev = '0; mOut = '0; mHw = hw; mVal = vs;
    #1;
    check(sampleOut == '0 && !sampleOutValid, "R11 reset out", {7'b0, sampleOutValid, sampleOut}, 32'h0);
    check(!errPulse, "R5 reset pulse", errPulse, 0);
    check(!irq, "R6 reset irq", irq, 0);
    check(regRdata == '0, "R12 reset rdata", regRdata, 0);
  endtask

  task automatic step(input bit fr, input logic [SW-1:0] smp, input logic [5:0] fl,
                      input bit rd, input bit wr, input logic [1:0] addr,
                      input logic [7:0] wd, input string tag);
    logic [6:0] hit, act, em;
    logic [7:0] expRd;
    logic [SW-1:0] expOut;
    string t;
    @(negedge clk);
    frameStb = fr; sampleIn = smp;
    parErr = fl[0]; bipErr = fl[1]; unlockErr = fl[2]; validBit = fl[3];
    csCrcErr = fl[4]; qCrcErr = fl[5];
    regRd = rd; regWr = wr; regAddr = addr; regWdata = wd;
    // model on pre-edge state
    em = effMaskOf();
    hit = fr ? (errVecOf(fl) & em) : 7'h0;
    act = hit & 7'h1F;
    expOut = mOut;
    if (fr) begin
      if (act != 0) begin
        case (mHw ? 2'd0 : mHold)
          2'd0: expOut = mPrev;
          2'd1: expOut = '0;
          default: expOut = smp;
        endcase
      end else begin
        expOut = smp;
        mPrev = smp;
      end
    end
    mOut = expOut;
    case (addr)
      2'd0: expRd = {1'b0, mStatus};
      2'd1: expRd = {1'b0, mMask};
      2'd2: expRd = {6'b0, mHold};
      default: expRd = 8'h0;
    endcase
    mStatus = ((rd && addr == 2'd0) ? 7'h0 : mStatus) | hit;
    if (wr && addr == 2'd1) mMask = wd[6:0];
    if (wr && addr == 2'd2) mHold = wd[1:0];
    @(posedge clk);
    #1;
    frameStb = 0; regRd = 0; regWr = 0;
    check(sampleOutValid == fr, (tag != "") ? tag : "R11 valid", sampleOutValid, fr);
    t = (tag != "") ? tag : (act != 0 ? (mHw ? "R10 sample" : "R7 sample") :
         (hit != 0 ? "R8 sample" : "R11 sample"));
    check(sampleOut == expOut, t, sampleOut, expOut);
    check(errPulse == (hit != 0), (tag != "") ? tag : "R5 pulse", errPulse, hit != 0);
    check(irq == ((mStatus & effMaskOf()) != 0), (tag != "") ? tag : "R6 irq", irq,
          (mStatus & effMaskOf()) != 0);
    if (rd)
      check(regRdata == expRd, (tag != "") ? tag : (addr == 0 ? "R3 read" : "R12 read"),
            regRdata, expRd);
  endtask

  task automatic readReg(input logic [1:0] a, input string tag);
    step(0, '0, 6'h0, 1, 0, a, 8'h0, tag);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d, input string tag);
    step(0, '0, 6'h0, 0, 1, a, d, tag);
  endtask

  task automatic randomRun(input int n);
    for (int i = 0; i < n; i++) begin
      logic [5:0] fl;
      bit fr, rd, wr;
      logic [1:0] a;
      for (int b = 0; b < 6; b++) fl[b] = ($urandom % 6) == 0;
      fr = ($urandom % 3) != 0;
      rd = ($urandom % 6) == 0;
      wr = !rd && (($urandom % 14) == 0);
      a = 2'($urandom % 4);
      if (wr) a = (($urandom % 2) == 0) ? 2'd1 : 2'd2;
      step(fr, SW'($urandom), fl, rd, wr, a, 8'($urandom), "");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    doReset(0, 0);
    readReg(0, "R4 status zero");
    readReg(1, "R4 mask zero");
    readReg(2, "R7 hold zero");
    step(1, 24'h111111, 6'h01, 0, 0, 0, 0, "R4 masked parity");
    readReg(0, "R4 masked not logged");
    writeReg(1, 8'hFF, "R12 mask write");
    readReg(1, "R2 mask bit7 reads 0");
    step(1, 24'hA0A0A0, 6'h00, 0, 0, 0, 0, "R11 good frame");
    step(1, 24'hB1B1B1, 6'h01, 0, 0, 0, 0, "R7 repeat on parity");
    readReg(0, "R2 parity bit0");
    readReg(0, "R3 cleared after read");
    step(1, 24'h222222, 6'h04, 0, 0, 0, 0, "R1 unlock");
    readReg(0, "R1 unlock gives 0x14");
    step(1, 24'h333333, 6'h02, 0, 0, 0, 0, "R1 biphase");
    readReg(0, "R1 biphase gives 0x06");
    step(1, 24'h444444, 6'h08, 0, 0, 0, 0, "R2 validity");
    readReg(0, "R2 validity bit3");
    step(1, 24'h555555, 6'h10, 0, 0, 0, 0, "R8 cs crc passes");
    step(1, 24'h666666, 6'h20, 0, 0, 0, 0, "R8 q crc passes");
    readReg(0, "R2 crc bits 5 and 6");
    writeReg(2, 8'h01, "R12 hold write");
    step(1, 24'h777777, 6'h01, 0, 0, 0, 0, "R7 zero mode");
    writeReg(2, 8'h02, "R12 hold write");
    step(1, 24'h888888, 6'h02, 0, 0, 0, 0, "R7 pass mode");
    writeReg(2, 8'h03, "R12 hold write");
    step(1, 24'h999999, 6'h04, 0, 0, 0, 0, "R7 pass alt");
    readReg(0, "R3 drain");
    step(1, 24'h121212, 6'h01, 1, 0, 0, 0, "R3 read with event");
    readReg(0, "R3 event survives clear");
    writeReg(1, 8'h01, "R4 partial mask");
    writeReg(2, 8'h00, "R12 hold write");
    step(1, 24'h343434, 6'h04, 0, 0, 0, 0, "R4 masked unlock untouched");
    readReg(0, "R4 unlock not logged");
    writeReg(0, 8'h7F, "R12 status write ignored");
    readReg(0, "R12 status still zero");
    readReg(3, "R12 addr3 zero");
    step(1, 24'h565656, 6'h01, 0, 0, 0, 0, "R6 irq set");
    writeReg(1, 8'h00, "R6 irq follows mask");
    writeReg(1, 8'h01, "R6 irq returns");

    doReset(0, 0);
    writeReg(1, 8'h7F, "R12 mask write");
    step(1, 24'hABCDEF, 6'h01, 0, 0, 0, 0, "R9 hold before good is zero");
    step(1, 24'h0C0C0C, 6'h00, 0, 0, 0, 0, "R9 good loads");
    step(1, 24'h0D0D0D, 6'h08, 0, 0, 0, 0, "R9 repeat good");
    writeReg(2, 8'h02, "R12 hold write");
    step(1, 24'h0E0E0E, 6'h01, 0, 0, 0, 0, "R9 pass no load");
    writeReg(2, 8'h00, "R12 hold write");
    step(1, 24'h0F0F0F, 6'h02, 0, 0, 0, 0, "R9 still old good");
    randomRun(3000);

    doReset(1, 1);
    step(1, 24'h010101, 6'h00, 0, 0, 0, 0, "R10 good");
    step(1, 24'h020202, 6'h08, 0, 0, 0, 0, "R10 validity holds");
    step(1, 24'h030303, 6'h01, 0, 0, 0, 0, "R10 parity holds");
    step(1, 24'h040404, 6'h30, 0, 0, 0, 0, "R10 crc masked");
    writeReg(2, 8'h01, "R10 hold reg ignored");
    step(1, 24'h050505, 6'h04, 0, 0, 0, 0, "R10 unlock holds");
    randomRun(1000);

    doReset(1, 0);
    validStrap = 1'b1;
    step(1, 24'h060606, 6'h08, 0, 0, 0, 0, "R10 validity ignored");
    step(1, 24'h070707, 6'h02, 0, 0, 0, 0, "R10 biphase holds");
    randomRun(1000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule